// File: doc/BRIEF.md
# Three-Wire Timekeeper Serial Master

This block drives a timekeeping chip over a three-wire link made of a chip-enable line, a serial clock and one bidirectional data line. A host on the same clock domain presents a register index, an operation code and, for writes, a data byte. The block turns that request into one or more framed serial transactions and answers with a one-cycle `done` strobe. For a read, the byte returned by the chip comes back on `rdData` in the same cycle.

The block guards the chip's write protection on its own. A host register write goes out as three frames. The first clears the write-protect bit in the chip's control register, the second carries the write, and the third sets write protect again. A read-only input blocks every register write except one to the trickle-charger register. A presence probe writes a marker byte into the chip's first RAM location, reads it back and latches a failure flag if the marker does not return.

After reset the block runs an initialisation sequence without host involvement. It programs the trickle-charger register, reads the seconds register and writes it back with its halt bit cleared. The host sees `busy` high until this sequence ends.

Top module: `rtc3w_master`

## Requirements
- R1: While `rstN` is low, `ceOut`, `sclkOut`, `sdaOe` and `done` are 0. Once reset is released, `busy` is 1 while the initialisation sequence runs.
- R2: Every byte on the link travels least-significant bit first. `sdaOut` changes only while `sclkOut` is low, and `sclkOut` is high only while `ceOut` is high.
- R3: A register write command is 0x80 OR (index << 1). A register read command is 0x81 OR (index << 1). The index is 5 bits wide.
- R4: A read frame is a command byte followed by 8 bits sampled from `sdaIn` at the end of each SCLK low half. The first bit sampled lands in bit 0 of `rdData`, which is valid in the cycle `done` is high.
- R5: `sdaOe` is 1 only while the block is sending a command or write byte. It is 0 for all eight bits of a read byte and whenever `ceOut` is low.
- R6: A frame raises `ceOut` only after it has been low for at least OPEN_UNITS ticks. After the last SCLK falling edge of the frame, `ceOut` falls exactly CLOSE_UNITS ticks later, with one tick equal to CLK_DIV clock cycles. `ceOut` is low whenever `busy` is low.
- R7: A register write (`reqOp`=1) produces three frames in order: 0x8E with data 0x00, then the write command with the data, then 0x8E with data 0x80.
- R8: With `readOnly`=1, a write to any index other than TRICKLE_IDX (default 8) puts no frame on the link and still pulses `done`. A write to TRICKLE_IDX proceeds with its three frames.
- R9: A probe (`reqOp`=2) produces four frames: 0x8E/0x00, 0xC0/0x42, a read with command 0xC1, and 0x8E/0x80. `probeFail` becomes 1 if the byte read is not 0x42. The flag is cleared only when the next probe starts and holds its value through other requests.
- R10: After reset, the block writes TRICKLE_IDX with {TRICKLE_UPPER, TRICKLE_CFG} inside an unlock/relock pair. It then reads index 0 and writes index 0 back with bit 7 cleared inside another pair. With `readOnly`=1, that write-back and its pair are omitted.
- R11: A request made while `busy` is 1 is ignored. `done` lasts exactly one cycle and is high only when `busy` is 0.
- R12: Each SCLK high half lasts exactly CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| readOnly | input | 1 | Blocks register writes except to the trickle-charger index |
| reqValid | input | 1 | Request strobe, taken when `busy` is 0 |
| reqOp | input | 2 | 0 read, 1 write, 2 probe, 3 no operation |
| reqIdx | input | 5 | Register index |
| reqData | input | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| rdData | output | 8 | Byte from the last read or probe |
| probeFail | output | 1 | Latched result of the last probe |
| ceOut | output | 1 | Chip enable to the timekeeper |
| sclkOut | output | 1 | Serial clock to the timekeeper |
| sdaOut | output | 1 | Data driven toward the timekeeper |
| sdaOe | output | 1 | Output enable for `sdaOut` |
| sdaIn | input | 1 | Data read back from the line |

## Verification
The hardest situation to reach from the ports is the initialisation path under read-only configuration. It runs only once after a reset, so the bench changes `readOnly` and the seconds value held in its chip model, applies a second reset mid-run, and counts the frames that follow. The failing probe is the next hardest case. The chip model is switched to absent, so the line floats high and every write is dropped. The latched flag is then watched through an ordinary read before a successful probe clears it.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int IDX_W = 5;

  localparam logic [7:0] WP_CMD    = 8'h8E;
  localparam logic [7:0] WP_OPEN   = 8'h00;
  localparam logic [7:0] WP_LOCK   = 8'h80;
  localparam logic [7:0] RAM0_WR   = 8'hC0;
  localparam logic [7:0] RAM0_RD   = 8'hC1;
  localparam logic [7:0] PROBE_PAT = 8'h42;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_PROBE = 2'd2, OP_NONE = 2'd3} hostOp_t;
  typedef enum logic [1:0] {J_INIT, J_READ, J_WRITE, J_PROBE} job_t;

  typedef struct packed {
    logic       start;
    logic       isRead;
    logic [7:0] cmd;
    logic [7:0] wdata;
  } txnStrobe_t;

  function automatic logic [7:0] cmdWrite(input logic [IDX_W-1:0] idx);
    return {2'b10, idx, 1'b0};
  endfunction

  function automatic logic [7:0] cmdRead(input logic [IDX_W-1:0] idx);
    return {2'b10, idx, 1'b1};
  endfunction
endpackage

// File: rtl/rtc3w_datapath.sv
module rtc3w_datapath
  import rtc3w_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int OPEN_UNITS  = 5,
  parameter int CLOSE_UNITS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  txnStrobe_t strobe,
  input  logic       sdaIn,
  output logic       txnDone,
  output logic [7:0] rxByte,
  output logic       ceOut,
  output logic       sclkOut,
  output logic       sdaOut,
  output logic       sdaOe
);
  localparam int DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int UNIT_MAX = (OPEN_UNITS > CLOSE_UNITS) ? OPEN_UNITS : CLOSE_UNITS;
  localparam int UNIT_W   = $clog2(UNIT_MAX + 1);

  typedef enum logic [2:0] {D_IDLE, D_OPEN, D_BITLO, D_BITHI, D_CLOSE} dpState_t;

  dpState_t          st;
  logic [UNIT_W-1:0] unitCnt;
  logic [3:0]        bitIdx;
  logic [7:0]        txReg;
  logic [7:0]        dataReg;
  logic [7:0]        rxReg;
  logic              rdMode;
  logic              running;
  logic              tick;

  assign running = (st != D_IDLE);
  assign rxByte  = rxReg;

  // Tick generator: one tick per SCLK half-period
  generate
    if (CLK_DIV == 1) begin : gDirect
      assign tick = running;
    end else begin : gDiv
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (!running || divCnt == DIV_W'(CLK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = running && (divCnt == DIV_W'(CLK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= D_IDLE;
      unitCnt <= '0;
      bitIdx  <= '0;
      txReg   <= '0;
      dataReg <= '0;
      rxReg   <= '0;
      rdMode  <= 1'b0;
      txnDone <= 1'b0;
      ceOut   <= 1'b0;
      sclkOut <= 1'b0;
      sdaOut  <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      txnDone <= 1'b0;
      case (st)
        D_IDLE: begin
          if (strobe.start) begin
            st      <= D_OPEN;
            unitCnt <= '0;
            bitIdx  <= '0;
            txReg   <= strobe.cmd;
            dataReg <= strobe.wdata;
            rdMode  <= strobe.isRead;
            ceOut   <= 1'b0;
            sclkOut <= 1'b0;
          end
        end
        D_OPEN: begin
          if (tick) begin
            if (unitCnt == UNIT_W'(OPEN_UNITS - 1)) begin
              ceOut  <= 1'b1;
              sdaOe  <= 1'b1;
              sdaOut <= txReg[0];
              st     <= D_BITLO;
            end else begin
              unitCnt <= unitCnt + 1'b1;
            end
          end
        end
        D_BITLO: begin
          if (tick) begin
            sclkOut <= 1'b1;
            st      <= D_BITHI;
            if (rdMode && bitIdx[3]) rxReg <= {sdaIn, rxReg[7:1]};
          end
        end
        D_BITHI: begin
          if (tick) begin
            sclkOut <= 1'b0;
            bitIdx  <= bitIdx + 4'd1;
            if (bitIdx == 4'd15) begin
              sdaOe   <= 1'b0;
              unitCnt <= '0;
              st      <= D_CLOSE;
            end else if (bitIdx == 4'd7) begin
              st <= D_BITLO;
              if (rdMode) begin
                sdaOe <= 1'b0;
              end else begin
                txReg  <= dataReg;
                sdaOut <= dataReg[0];
              end
            end else begin
              st     <= D_BITLO;
              txReg  <= {1'b0, txReg[7:1]};
              sdaOut <= txReg[1];
            end
          end
        end
        D_CLOSE: begin
          if (tick) begin
            if (unitCnt == UNIT_W'(CLOSE_UNITS - 1)) begin
              ceOut   <= 1'b0;
              txnDone <= 1'b1;
              st      <= D_IDLE;
            end else begin
              unitCnt <= unitCnt + 1'b1;
            end
          end
        end
        default: st <= D_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_ctrl.sv
module rtc3w_ctrl
  import rtc3w_pkg::*;
#(
  parameter logic [IDX_W-1:0] TRICKLE_IDX   = 5'd8,
  parameter logic [3:0]       TRICKLE_UPPER = 4'hA,
  parameter logic [3:0]       TRICKLE_CFG   = 4'h5,
  parameter logic [IDX_W-1:0] SECONDS_IDX   = 5'd0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             readOnly,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [7:0]       reqData,
  output txnStrobe_t       strobe,
  input  logic             txnDone,
  input  logic [7:0]       rxByte,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rdData,
  output logic             probeFail
);
  typedef enum logic [1:0] {C_IDLE, C_LAUNCH, C_WAIT, C_FIN} ctlState_t;

  ctlState_t        cState;
  job_t             job;
  logic [2:0]       step;
  logic [2:0]       lastStep;
  logic [IDX_W-1:0] idxR;
  logic [7:0]       dataR;
  logic [7:0]       holdR;
  logic [7:0]       tCmd;
  logic [7:0]       tData;
  logic             tRead;

  // Frame table: which command and data each step of each job sends
  always_comb begin
    tCmd     = WP_CMD;
    tData    = WP_OPEN;
    tRead    = 1'b0;
    lastStep = 3'd0;
    case (job)
      J_READ: begin
        tCmd  = cmdRead(idxR);
        tRead = 1'b1;
      end
      J_WRITE: begin
        lastStep = 3'd2;
        case (step)
          3'd0: ;
          3'd1: begin tCmd = cmdWrite(idxR); tData = dataR; end
          default: tData = WP_LOCK;
        endcase
      end
      J_PROBE: begin
        lastStep = 3'd3;
        case (step)
          3'd0: ;
          3'd1: begin tCmd = RAM0_WR; tData = PROBE_PAT; end
          3'd2: begin tCmd = RAM0_RD; tRead = 1'b1; end
          default: tData = WP_LOCK;
        endcase
      end
      default: begin
        lastStep = readOnly ? 3'd3 : 3'd6;
        case (step)
          3'd0: ;
          3'd1: begin tCmd = cmdWrite(TRICKLE_IDX); tData = {TRICKLE_UPPER, TRICKLE_CFG}; end
          3'd2: tData = WP_LOCK;
          3'd3: begin tCmd = cmdRead(SECONDS_IDX); tRead = 1'b1; end
          3'd4: ;
          3'd5: begin tCmd = cmdWrite(SECONDS_IDX); tData = holdR & 8'h7F; end
          default: tData = WP_LOCK;
        endcase
      end
    endcase
  end

  assign strobe.start  = (cState == C_LAUNCH);
  assign strobe.isRead = tRead;
  assign strobe.cmd    = tCmd;
  assign strobe.wdata  = tData;
  assign busy          = (cState != C_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cState    <= C_LAUNCH;
      job       <= J_INIT;
      step      <= '0;
      idxR      <= '0;
      dataR     <= '0;
      holdR     <= '0;
      done      <= 1'b0;
      rdData    <= '0;
      probeFail <= 1'b0;
    end else begin
      done <= 1'b0;
      case (cState)
        C_IDLE: begin
          if (reqValid) begin
            idxR  <= reqIdx;
            dataR <= reqData;
            step  <= '0;
            case (hostOp_t'(reqOp))
              OP_READ: begin
                job    <= J_READ;
                cState <= C_LAUNCH;
              end
              OP_WRITE: begin
                job    <= J_WRITE;
                cState <= (readOnly && reqIdx != TRICKLE_IDX) ? C_FIN : C_LAUNCH;
              end
              OP_PROBE: begin
                job       <= J_PROBE;
                probeFail <= 1'b0;
                cState    <= C_LAUNCH;
              end
              default: ;
            endcase
          end
        end
        C_LAUNCH: cState <= C_WAIT;
        C_WAIT: begin
          if (txnDone) begin
            if (tRead) holdR <= rxByte;
            if (step == lastStep) cState <= C_FIN;
            else begin
              step   <= step + 3'd1;
              cState <= C_LAUNCH;
            end
          end
        end
        default: begin
          cState <= C_IDLE;
          if (job != J_INIT) done <= 1'b1;
          if (job == J_READ || job == J_PROBE) rdData <= holdR;
          if (job == J_PROBE) probeFail <= (holdR != PROBE_PAT);
        end
      endcase
    end
  end
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int                CLK_DIV       = 4,
  parameter int                OPEN_UNITS    = 5,
  parameter int                CLOSE_UNITS   = 2,
  parameter logic [IDX_W-1:0]  TRICKLE_IDX   = 5'd8,
  parameter logic [3:0]        TRICKLE_UPPER = 4'hA,
  parameter logic [3:0]        TRICKLE_CFG   = 4'h5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       readOnly,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [4:0] reqIdx,
  input  logic [7:0] reqData,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  output logic       probeFail,
  output logic       ceOut,
  output logic       sclkOut,
  output logic       sdaOut,
  output logic       sdaOe,
  input  logic       sdaIn
);
  txnStrobe_t strobe;
  logic       txnDone;
  logic [7:0] rxByte;

  rtc3w_ctrl #(
    .TRICKLE_IDX(TRICKLE_IDX), .TRICKLE_UPPER(TRICKLE_UPPER),
    .TRICKLE_CFG(TRICKLE_CFG), .SECONDS_IDX(5'd0)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .readOnly(readOnly), .reqValid(reqValid),
    .reqOp(reqOp), .reqIdx(reqIdx), .reqData(reqData), .strobe(strobe),
    .txnDone(txnDone), .rxByte(rxByte), .busy(busy), .done(done),
    .rdData(rdData), .probeFail(probeFail)
  );

  rtc3w_datapath #(
    .CLK_DIV(CLK_DIV), .OPEN_UNITS(OPEN_UNITS), .CLOSE_UNITS(CLOSE_UNITS)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaIn(sdaIn),
    .txnDone(txnDone), .rxByte(rxByte), .ceOut(ceOut), .sclkOut(sclkOut),
    .sdaOut(sdaOut), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/rtc3w_checker.sv
module rtc3w_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic ceOut,
  input logic sclkOut,
  input logic sdaOut,
  input logic sdaOe
);
  AST_SCLK_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN) sclkOut |-> ceOut); // R2
  AST_DATA_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rstN) sclkOut |-> $stable(sdaOut)); // R2
  AST_DRIVE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN) sdaOe |-> ceOut); // R5
  AST_CE_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !ceOut); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R11
endmodule

bind rtc3w_master rtc3w_checker uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .ceOut(ceOut),
  .sclkOut(sclkOut), .sdaOut(sdaOut), .sdaOe(sdaOe)
);

// File: tb/tb_rtc3w_master.sv
module tb_rtc3w_master;
  localparam int DIV = 4;
  localparam int OPENU = 5;
  localparam int CLOSEU = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic readOnly = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [4:0] reqIdx = 5'd0;
  logic [7:0] reqData = 8'd0;
  logic busy, done, probeFail, ceOut, sclkOut, sdaOut, sdaOe, sdaIn;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc3w_master #(.CLK_DIV(DIV), .OPEN_UNITS(OPENU), .CLOSE_UNITS(CLOSEU)) dut (
    .clk(clk), .rstN(rstN), .readOnly(readOnly), .reqValid(reqValid), .reqOp(reqOp),
    .reqIdx(reqIdx), .reqData(reqData), .busy(busy), .done(done), .rdData(rdData),
    .probeFail(probeFail), .ceOut(ceOut), .sclkOut(sclkOut), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  // Chip model
  logic [7:0] regs [0:31];
  logic [7:0] ram  [0:31];
  logic       wp = 1'b1;
  logic       absent = 1'b0;
  logic       slaveDrive = 1'b1;
  logic [7:0] sCmd, sDat, sRead;
  int         sBit = 0;
  logic [7:0] logCmd [0:63];
  logic [7:0] logData [0:63];
  int         logN = 0;
  int         fmtErr = 0;

  assign sdaIn = sdaOe ? sdaOut : (absent ? 1'b1 : slaveDrive);

  always @(posedge ceOut) begin
    sBit = 0; sCmd = 8'h00; sDat = 8'h00;
  end

  always @(posedge sclkOut) begin
    if (ceOut) begin
      if (sBit < 8) begin
        if (!sdaOe) fmtErr++;
        sCmd[sBit] = sdaOut;
      end else if (!sCmd[0]) begin
        if (!sdaOe) fmtErr++;
        sDat[sBit-8] = sdaOut;
      end else if (sdaOe) fmtErr++;
      sBit++;
      if (sBit == 8 && sCmd[0]) sRead = sCmd[6] ? ram[sCmd[5:1]] : regs[sCmd[5:1]];
      if (sBit >= 8 && sBit <= 15 && sCmd[0]) slaveDrive = sRead[sBit-8];
    end
  end

  always @(negedge ceOut) begin
    if (sBit == 16) begin
      if (logN < 64) begin
        logCmd[logN] = sCmd;
        logData[logN] = sCmd[0] ? (absent ? 8'hFF : sRead) : sDat;
        logN++;
      end
      if (!absent && sCmd[7] && !sCmd[0]) begin
        if (sCmd == 8'h8E) wp = sDat[7];
        else if (!wp) begin
          if (sCmd[6]) ram[sCmd[5:1]] = sDat;
          else regs[sCmd[5:1]] = sDat;
        end
      end
      sBit = 0;
    end
  end

  // Timing monitors
  int hiCnt = 0, hiErr = 0, hiSeen = 0;
  int lowCnt = 0, openErr = 0, closeCnt = 0, closeErr = 0, closeSeen = 0;
  logic prevCe = 1'b0;
  always @(negedge clk) begin
    if (sclkOut) hiCnt++;
    else if (hiCnt != 0) begin
      hiSeen++;
      if (hiCnt != DIV) hiErr++;
      hiCnt = 0;
    end
    if (ceOut && sBit == 16 && !sclkOut) closeCnt++;
    if (prevCe && !ceOut) begin
      closeSeen++;
      if (closeCnt != CLOSEU * DIV) closeErr++;
    end
    if (!prevCe && ceOut) begin
      if (lowCnt < OPENU * DIV) openErr++;
      lowCnt = 0;
      closeCnt = 0;
    end
    if (!ceOut) lowCnt++;
    prevCe = ceOut;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkTxn(input int k, input logic [7:0] c, input logic [7:0] d, input string req);
    chk(logCmd[k] == c, req, logCmd[k], c);
    chk(logData[k] == d, req, logData[k], d);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic doReq(input logic [1:0] op, input logic [4:0] idx, input logic [7:0] d,
                       output logic [7:0] rd, input string req);
    bit got = 0;
    rd = 8'h00;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqIdx = idx; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      if (done) begin got = 1; rd = rdData; end
      else @(negedge clk);
    end
    chk(got, req, 0, 1);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ceOut && !sclkOut && !sdaOe && !done, "R1 reset outputs", {ceOut, sclkOut, sdaOe, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy, "R1 busy after reset", busy, 1);
  endtask

  task automatic testInit();
    waitIdle();
    chk(logN == 7, "R10 init frame count", logN, 7);
    chkTxn(0, 8'h8E, 8'h00, "R10 R7 unlock");
    chkTxn(1, 8'h90, 8'hA5, "R10 R3 trickle write");
    chkTxn(2, 8'h8E, 8'h80, "R10 relock");
    chkTxn(3, 8'h81, 8'h85, "R10 seconds read");
    chkTxn(5, 8'h80, 8'h05, "R10 halt cleared");
    chk(regs[0] == 8'h05, "R10 seconds stored", regs[0], 8'h05);
    chk(regs[8] == 8'hA5, "R10 trickle stored", regs[8], 8'hA5);
  endtask

  task automatic testRead();
    logic [7:0] rd;
    int base = logN;
    regs[3] = 8'h1D;
    doReq(2'd0, 5'd3, 8'h00, rd, "R4 read done");
    chk(rd == 8'h1D, "R4 read lsb first", rd, 8'h1D);
    chk(logN == base + 1, "R4 read one frame", logN - base, 1);
    chk(logCmd[base] == 8'h87, "R3 read command", logCmd[base], 8'h87);
  endtask

  task automatic testWrite();
    logic [7:0] rd;
    int base = logN;
    doReq(2'd1, 5'd5, 8'h37, rd, "R7 write done");
    chk(logN == base + 3, "R7 three frames", logN - base, 3);
    chkTxn(base, 8'h8E, 8'h00, "R7 unlock");
    chkTxn(base + 1, 8'h8A, 8'h37, "R7 R3 write frame");
    chkTxn(base + 2, 8'h8E, 8'h80, "R7 relock");
    chk(regs[5] == 8'h37 && wp, "R7 stored and locked", regs[5], 8'h37);
  endtask

  task automatic testReadOnly();
    logic [7:0] rd;
    int base = logN;
    readOnly = 1'b1;
    doReq(2'd1, 5'd5, 8'h99, rd, "R8 blocked write done");
    chk(logN == base, "R8 no frames", logN - base, 0);
    chk(regs[5] == 8'h37, "R8 register kept", regs[5], 8'h37);
    doReq(2'd1, 5'd8, 8'hA7, rd, "R8 trickle done");
    chk(logN == base + 3, "R8 trickle frames", logN - base, 3);
    chkTxn(base + 1, 8'h90, 8'hA7, "R8 trickle frame");
    chk(regs[8] == 8'hA7, "R8 trickle stored", regs[8], 8'hA7);
    readOnly = 1'b0;
  endtask

  task automatic testProbe();
    logic [7:0] rd;
    int base = logN;
    doReq(2'd2, 5'd0, 8'h00, rd, "R9 probe done");
    chk(logN == base + 4, "R9 four frames", logN - base, 4);
    chkTxn(base, 8'h8E, 8'h00, "R9 unlock");
    chkTxn(base + 1, 8'hC0, 8'h42, "R9 pattern write");
    chkTxn(base + 2, 8'hC1, 8'h42, "R9 pattern read");
    chkTxn(base + 3, 8'h8E, 8'h80, "R9 relock");
    chk(!probeFail && rd == 8'h42, "R9 present", probeFail, 0);
    absent = 1'b1;
    doReq(2'd2, 5'd0, 8'h00, rd, "R9 absent probe done");
    chk(probeFail && rd == 8'hFF, "R9 absent flagged", probeFail, 1);
    absent = 1'b0;
    doReq(2'd0, 5'd3, 8'h00, rd, "R9 read after fail");
    chk(probeFail, "R9 flag latched", probeFail, 1);
    doReq(2'd2, 5'd0, 8'h00, rd, "R9 reprobe done");
    chk(!probeFail, "R9 flag cleared", probeFail, 0);
  endtask

  task automatic testBusyIgnore();
    int base = logN;
    bit got = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; reqIdx = 5'd3;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy, "R11 busy during read", busy, 1);
    reqValid = 1'b1; reqOp = 2'd1; reqIdx = 5'd5; reqData = 8'hEE;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 20000 && !got; i++) begin
      if (done) got = 1;
      else @(negedge clk);
    end
    chk(got && rdData == 8'h1D, "R11 first request completes", rdData, 8'h1D);
    repeat (20) @(negedge clk);
    chk(!busy && logN == base + 1, "R11 second request ignored", logN - base, 1);
    chk(regs[5] == 8'h37, "R11 register untouched", regs[5], 8'h37);
  endtask

  task automatic testInitReadOnly();
    int base;
    readOnly = 1'b1;
    regs[0] = 8'h92;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    base = logN;
    rstN = 1'b1;
    waitIdle();
    chk(logN == base + 4, "R10 read-only init frames", logN - base, 4);
    chkTxn(base + 3, 8'h81, 8'h92, "R10 read-only seconds read");
    chk(regs[0] == 8'h92, "R10 seconds kept", regs[0], 8'h92);
    readOnly = 1'b0;
  endtask

  task automatic testTiming();
    chk(fmtErr == 0, "R2 R5 drive direction", fmtErr, 0);
    chk(hiErr == 0 && hiSeen > 0, "R12 high half", hiErr, 0);
    chk(openErr == 0, "R6 open low time", openErr, 0);
    chk(closeErr == 0 && closeSeen > 0, "R6 close time", closeErr, 0);
  endtask

  bit finished = 0;

  initial begin
    for (int i = 0; i < 32; i++) begin regs[i] = 8'h00; ram[i] = 8'h00; end
    regs[0] = 8'h85;
    testReset();
    testInit();
    testRead();
    testWrite();
    testReadOnly();
    testProbe();
    testBusyIgnore();
    testInitReadOnly();
    testTiming();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule